// File: doc/BRIEF.md
# GCR Read Sync and Byte Framer

This block sits behind a disk read channel's data separator. It takes one recovered bit per strobe into a 10-bit shift register. It spots the run of ones that marks a sync field and splits the bits that follow into 10-bit groups. Each group holds two 5-bit codes of the 4-to-5 group code. The block also counts groups after sync, so that a header-sync flag can be raised at a fixed distance from the sync field. Every status flag is active-low, and each returns to 1 when the channel is idle.

In read mode the code table turns the shift register into a byte and reports illegal codes. In write mode the same table is addressed with a host byte and a write-sync bit, and it returns the 10-bit pattern to record. A latched byte-ready flag holds a byte-ready event until the host touches the data port.

Top module: `gcr_read_framer`

## Requirements
- R1: In read mode (rd_mode_i=1), data_o[9:8] is 0, data_o[7:4] is the nibble decoded from shift bits 9:5 and data_o[3:0] is the nibble decoded from bits 4:0. Each accepted bit enters bit 0 and the oldest bit leaves from bit 9. A half that holds no valid code reads as nibble 0.
- R2: After each strobe, sync_no is 0 exactly when the last ten accepted bits are all 1.
- R3: A bit counter is forced to 0 on any strobe that leaves sync active, and it stays 0 on the first strobe after sync goes inactive. On every other strobe it steps 0..9 and wraps. brdy_no is 0 while the counter holds 9, so the first byte-ready falls on the tenth bit after sync ends.
- R4: A group counter is loaded with 10 on each strobe with sync active, and it steps modulo 16 each time the bit counter wraps from 9 to 0. syn_no is 0 while the counter holds 15, which is from the 51st to the 60th bit after sync ends.
- R5: gcr_err_no is 0 only when brdy_no is 0, rd_mode_i is 1 and at least one 5-bit half of the shift register holds no valid code.
- R6: lbrdy_no goes to 0 on the strobe that sets byte-ready and returns to 1 on a cycle with host_acc_i=1. When both fall in the same cycle, it goes to 0.
- R7: In write mode (rd_mode_i=0), data_o is {code(wr_data_i[7:4]), code(wr_data_i[3:0])}, or all ones when wr_sync_i=1. gcr_err_no stays 1.
- R8: The code table maps nibbles to codes as follows: 0→01010, 1→01011, 2→10010, 3→10011, 4→01110, 5→01111, 6→10110, 7→10111, 8→01001, 9→11001, A→11010, B→11011, C→01101, D→11101, E→11110, F→10101. No other 5-bit value is valid.
- R9: A clock edge with run_i=0 sets sync_no, brdy_no, lbrdy_no and syn_no to 1 and clears the shift register and both counters. gcr_err_no is then 1 as well.
- R10: Without bit_vld_i, bit_i is ignored, and the shift register, the counters, sync_no, brdy_no and syn_no hold their values.
- R11: While rst_ni is low, the block is held in the same idle state as in R9, independent of the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Channel active; 0 forces idle |
| bit_vld_i | input | 1 | One-cycle strobe qualifying bit_i |
| bit_i | input | 1 | Recovered read bit |
| rd_mode_i | input | 1 | 1 read mode, 0 write mode |
| wr_data_i | input | 8 | Byte to encode in write mode |
| wr_sync_i | input | 1 | Write-mode request for a sync pattern |
| host_acc_i | input | 1 | Host read or write of the data port |
| data_o | output | 10 | Decoded byte (read) or code pattern (write) |
| sync_no | output | 1 | Sync field seen, active low |
| brdy_no | output | 1 | Byte ready, active low |
| lbrdy_no | output | 1 | Latched byte ready, active low |
| syn_no | output | 1 | Header sync, active low, group count 15 |
| gcr_err_no | output | 1 | Illegal code at byte-ready, active low |

## Verification
The latched byte-ready flag has two causes that can arrive in the same clock: a strobe that completes a group and a host access to the data port. The bench times the host access onto the tenth bit of a group, so that both land on the same edge. It expects the flag to end low. It then checks that a host access on its own, with no strobe, raises the flag again.

// File: rtl/gcr_framer_pkg.sv
`timescale 1ns/1ps
package gcr_framer_pkg;

  typedef struct packed {
    logic       ok;
    logic [3:0] nib;
  } gcr_dec_t;

  function automatic logic [4:0] gcr_enc(input logic [3:0] nib);
    logic [4:0] c;
    case (nib)
      4'h0: c = 5'b01010;
      4'h1: c = 5'b01011;
      4'h2: c = 5'b10010;
      4'h3: c = 5'b10011;
      4'h4: c = 5'b01110;
      4'h5: c = 5'b01111;
      4'h6: c = 5'b10110;
      4'h7: c = 5'b10111;
      4'h8: c = 5'b01001;
      4'h9: c = 5'b11001;
      4'ha: c = 5'b11010;
      4'hb: c = 5'b11011;
      4'hc: c = 5'b01101;
      4'hd: c = 5'b11101;
      4'he: c = 5'b11110;
      default: c = 5'b10101;
    endcase
    return c;
  endfunction

  // inverse built by search so the code list lives in one place
  function automatic gcr_dec_t gcr_dec(input logic [4:0] code);
    gcr_dec_t r;
    r = '0;
    for (int n = 0; n < 16; n++) begin
      if (gcr_enc(4'(n)) == code) begin
        r.ok  = 1'b1;
        r.nib = 4'(n);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/gcr_code_table.sv
`timescale 1ns/1ps
module gcr_code_table
  import gcr_framer_pkg::*;
#(
  parameter int unsigned GRP_W = 10
) (
  input  logic [GRP_W:0]   addr_i,
  output logic [GRP_W-1:0] word_o,
  output logic             ok_o
);

  localparam int unsigned CODE_W = 5;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned HALVES = GRP_W / CODE_W;
  localparam int unsigned RD_W   = HALVES * NIB_W;

  logic [HALVES-1:0] half_ok;
  logic [RD_W-1:0]   rd_word;

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    gcr_dec_t d;
    assign d                     = gcr_dec(addr_i[h*CODE_W +: CODE_W]);
    assign half_ok[h]            = d.ok;
    assign rd_word[h*NIB_W +: NIB_W] = d.nib;
  end

  // write address: bit 10 = 0, hi nibble 8:5, sync 4, lo nibble 3:0
  always_comb begin
    word_o = '0;
    ok_o   = 1'b1;
    if (addr_i[GRP_W]) begin
      word_o[RD_W-1:0] = rd_word;
      ok_o             = &half_ok;
    end else if (addr_i[4]) begin
      word_o = '1;
      ok_o   = !addr_i[GRP_W-1];
    end else begin
      word_o = GRP_W'({gcr_enc(addr_i[8:5]), gcr_enc(addr_i[3:0])});
      ok_o   = !addr_i[GRP_W-1];
    end
  end

endmodule

// File: rtl/gcr_bit_framer.sv
`timescale 1ns/1ps
module gcr_bit_framer #(
  parameter int unsigned GRP_W    = 10,
  parameter int unsigned GRP_MOD  = 16,
  parameter int unsigned GRP_LOAD = 10,
  parameter int unsigned HDR_GRP  = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  input  logic             host_acc_i,
  output logic [GRP_W-1:0] shift_o,
  output logic             sync_no,
  output logic             brdy_no,
  output logic             lbrdy_no,
  output logic             syn_no
);

  localparam int unsigned CNT_W = $clog2(GRP_W);
  localparam int unsigned GCW   = $clog2(GRP_MOD);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GRP_W - 1);
  localparam logic [GCW-1:0]   GRP_TOP  = GCW'(GRP_MOD - 1);

  logic [GRP_W-1:0] shift_q, shift_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GCW-1:0]   grp_q, grp_d;
  logic sync_n_q, brdy_n_q, lbrdy_n_q, syn_n_q;
  logic sync_d, adv, wrap, brdy_d, syn_d;

  always_comb begin
    shift_d = {shift_q[GRP_W-2:0], bit_i};
    sync_d  = &shift_d;
    // first bit after sync leaves the count at 0
    adv     = !sync_d && sync_n_q;
    wrap    = adv && (cnt_q == CNT_LAST);
    cnt_d   = cnt_q;
    grp_d   = grp_q;
    if (sync_d) begin
      cnt_d = '0;
      grp_d = GCW'(GRP_LOAD);
    end else if (adv) begin
      cnt_d = wrap ? '0 : cnt_q + 1'b1;
      if (wrap) grp_d = (grp_q == GRP_TOP) ? '0 : grp_q + 1'b1;
    end
    brdy_d = (cnt_d == CNT_LAST);
    syn_d  = (grp_d == GCW'(HDR_GRP));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q   <= '0;
      cnt_q     <= '0;
      grp_q     <= '0;
      sync_n_q  <= 1'b1;
      brdy_n_q  <= 1'b1;
      lbrdy_n_q <= 1'b1;
      syn_n_q   <= 1'b1;
    end else if (!run_i) begin
      shift_q   <= '0;
      cnt_q     <= '0;
      grp_q     <= '0;
      sync_n_q  <= 1'b1;
      brdy_n_q  <= 1'b1;
      lbrdy_n_q <= 1'b1;
      syn_n_q   <= 1'b1;
    end else begin
      if (bit_vld_i) begin
        shift_q  <= shift_d;
        cnt_q    <= cnt_d;
        grp_q    <= grp_d;
        sync_n_q <= !sync_d;
        brdy_n_q <= !brdy_d;
        syn_n_q  <= !syn_d;
      end
      // new byte wins over a host access in the same cycle
      if (bit_vld_i && brdy_d) lbrdy_n_q <= 1'b0;
      else if (host_acc_i)     lbrdy_n_q <= 1'b1;
    end
  end

  assign shift_o  = shift_q;
  assign sync_no  = sync_n_q;
  assign brdy_no  = brdy_n_q;
  assign lbrdy_no = lbrdy_n_q;
  assign syn_no   = syn_n_q;

  // R3
  brdy_off_in_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_n_q |-> brdy_n_q);

  // R3
  brdy_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(brdy_n_q) |-> $past(bit_vld_i));

  // R4
  syn_off_in_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_n_q |-> syn_n_q);

  // R6
  lbrdy_follows_brdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(brdy_n_q) |-> !lbrdy_n_q);

  // R9
  idle_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (sync_n_q && brdy_n_q && lbrdy_n_q && syn_n_q));

  // R10
  hold_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !bit_vld_i) |=> ($stable(shift_q) && $stable(cnt_q) &&
                               $stable(grp_q) && $stable(brdy_n_q)));

endmodule

// File: rtl/gcr_read_framer.sv
`timescale 1ns/1ps
module gcr_read_framer #(
  parameter int unsigned GRP_W    = 10,
  parameter int unsigned GRP_MOD  = 16,
  parameter int unsigned GRP_LOAD = 10,
  parameter int unsigned HDR_GRP  = 15,
  localparam int unsigned BYTE_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              bit_vld_i,
  input  logic              bit_i,
  input  logic              rd_mode_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              wr_sync_i,
  input  logic              host_acc_i,
  output logic [GRP_W-1:0]  data_o,
  output logic              sync_no,
  output logic              brdy_no,
  output logic              lbrdy_no,
  output logic              syn_no,
  output logic              gcr_err_no
);

  logic [GRP_W-1:0] shift;
  logic [GRP_W:0]   tbl_addr;
  logic             tbl_ok;
  logic             brdy_n;

  gcr_bit_framer #(
    .GRP_W   (GRP_W),
    .GRP_MOD (GRP_MOD),
    .GRP_LOAD(GRP_LOAD),
    .HDR_GRP (HDR_GRP)
  ) u_framer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .bit_vld_i (bit_vld_i),
    .bit_i     (bit_i),
    .host_acc_i(host_acc_i),
    .shift_o   (shift),
    .sync_no   (sync_no),
    .brdy_no   (brdy_n),
    .lbrdy_no  (lbrdy_no),
    .syn_no    (syn_no)
  );

  assign tbl_addr = rd_mode_i
    ? {1'b1, shift}
    : (GRP_W+1)'({2'b00, wr_data_i[7:4], wr_sync_i, wr_data_i[3:0]});

  gcr_code_table #(.GRP_W(GRP_W)) u_table (
    .addr_i(tbl_addr),
    .word_o(data_o),
    .ok_o  (tbl_ok)
  );

  assign brdy_no    = brdy_n;
  assign gcr_err_no = brdy_n | tbl_ok;

  // R7
  write_no_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_mode_i |-> gcr_err_no);

  // R2
  sync_from_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && bit_vld_i && !bit_i) |=> sync_no);

endmodule

// File: tb/gcr_read_framer_tb.sv
`timescale 1ns/1ps
module gcr_read_framer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b1;
  logic       bit_vld = 1'b0;
  logic       bit_in = 1'b0;
  logic       rd_mode = 1'b1;
  logic [7:0] wr_data = 8'h00;
  logic       wr_sync = 1'b0;
  logic       host_acc = 1'b0;
  logic [9:0] data;
  logic       sync_n, brdy_n, lbrdy_n, syn_n, err_n;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  gcr_read_framer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .bit_vld_i(bit_vld), .bit_i(bit_in),
    .rd_mode_i(rd_mode), .wr_data_i(wr_data), .wr_sync_i(wr_sync), .host_acc_i(host_acc),
    .data_o(data), .sync_no(sync_n), .brdy_no(brdy_n), .lbrdy_no(lbrdy_n),
    .syn_no(syn_n), .gcr_err_no(err_n)
  );

  // R8 code list, indexed by nibble
  localparam logic [4:0] CODE [16] = '{
    5'b01010, 5'b01011, 5'b10010, 5'b10011, 5'b01110, 5'b01111, 5'b10110, 5'b10111,
    5'b01001, 5'b11001, 5'b11010, 5'b11011, 5'b01101, 5'b11101, 5'b11110, 5'b10101};

  // {sync ones[7:0], raw flag, payload[39:0]}; raw sends 40 bits, else 4 bytes encoded
  localparam int NV = 5;
  localparam logic [48:0] VEC [NV] = '{
    {8'd10, 1'b0, 40'h00_5AC3_0F96},
    {8'd15, 1'b0, 40'h00_FFEE_0011},
    {8'd0,  1'b1, 40'h00_0000_0000},
    {8'd12, 1'b1, 40'hFF_C000_1234},
    {8'd10, 1'b0, 40'h00_1234_5678}};

  // reference state
  logic [9:0] m_shift;
  int  m_cnt, m_grp;
  logic m_in_sync, m_lbrdy_n;

  function automatic logic legal(input logic [4:0] c);
    for (int n = 0; n < 16; n++) if (CODE[n] == c) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [3:0] nib_of(input logic [4:0] c);
    for (int n = 0; n < 16; n++) if (CODE[n] == c) return 4'(n);
    return 4'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    m_shift = '0; m_cnt = 0; m_grp = 0; m_in_sync = 1'b0; m_lbrdy_n = 1'b1;
  endtask

  task automatic check_all();
    logic brdy, bad;
    brdy = (m_cnt == 9);
    bad  = !(legal(m_shift[9:5]) && legal(m_shift[4:0]));
    chk("R2 sync_no", 32'(sync_n), 32'(!(&m_shift)));
    chk("R3 brdy_no", 32'(brdy_n), 32'(!brdy));
    chk("R4 syn_no", 32'(syn_n), 32'(!(m_grp == 15)));
    chk("R6 lbrdy_no", 32'(lbrdy_n), 32'(m_lbrdy_n));
    if (rd_mode) begin
      chk("R5 gcr_err_no", 32'(err_n), 32'(!(brdy && bad)));
      chk("R1 data_o", 32'(data), 32'({2'b00, nib_of(m_shift[9:5]), nib_of(m_shift[4:0])}));
    end else begin
      chk("R7 gcr_err_no write", 32'(err_n), 32'd1);
    end
  endtask

  task automatic step(input logic b, input logic acc);
    logic s;
    bit_vld = 1'b1; bit_in = b; host_acc = acc;
    @(negedge clk);
    bit_vld = 1'b0; host_acc = 1'b0;
    m_shift = {m_shift[8:0], b};
    s = &m_shift;
    if (s) begin
      m_cnt = 0; m_grp = 10;
    end else if (!m_in_sync) begin
      if (m_cnt == 9) begin m_cnt = 0; m_grp = (m_grp + 1) % 16; end
      else m_cnt++;
    end
    m_in_sync = s;
    if (m_cnt == 9) m_lbrdy_n = 1'b0;
    else if (acc)   m_lbrdy_n = 1'b1;
    check_all();
  endtask

  task automatic send_byte(input logic [7:0] v);
    logic [9:0] c;
    c = {CODE[v[7:4]], CODE[v[3:0]]};
    for (int i = 9; i >= 0; i--) step(c[i], 1'b0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    finish_run();
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    // R11 reset state, asynchronous hold
    chk("R11 sync_no", 32'(sync_n), 32'd1);
    chk("R11 brdy_no", 32'(brdy_n), 32'd1);
    chk("R11 lbrdy_no", 32'(lbrdy_n), 32'd1);
    chk("R11 syn_no", 32'(syn_n), 32'd1);
    chk("R11 gcr_err_no", 32'(err_n), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // vector walk, read mode
    for (int v = 0; v < NV; v++) begin
      for (int k = 0; k < int'(VEC[v][48:41]); k++) step(1'b1, 1'b0);
      if (VEC[v][40]) begin
        for (int i = 39; i >= 0; i--) step(VEC[v][i], 1'b0);
      end else begin
        for (int j = 3; j >= 0; j--) send_byte(VEC[v][j*8 +: 8]);
      end
    end

    // R3 R4 timing after sync
    begin
      int bitno, first_b, first_s, cnt_s;
      first_b = 0; first_s = 0; cnt_s = 0; bitno = 0;
      for (int k = 0; k < 10; k++) step(1'b1, 1'b0);
      for (int j = 0; j < 6; j++) begin
        for (int i = 9; i >= 0; i--) begin
          step(CODE[0][i % 5], 1'b0);
          bitno++;
          if (!brdy_n && first_b == 0) first_b = bitno;
          if (!syn_n) begin cnt_s++; if (first_s == 0) first_s = bitno; end
        end
      end
      chk("R3 first byte-ready bit", 32'(first_b), 32'd10);
      chk("R4 first header-sync bit", 32'(first_s), 32'd51);
      chk("R4 header-sync length", 32'(cnt_s), 32'd10);
    end

    // R6 host access alone, then coincident with byte-ready
    host_acc = 1'b1;
    @(negedge clk);
    host_acc = 1'b0; m_lbrdy_n = 1'b1;
    chk("R6 host access sets", 32'(lbrdy_n), 32'd1);
    begin
      logic [9:0] c;
      c = {CODE[4'h7], CODE[4'hc]};
      for (int i = 9; i >= 1; i--) step(c[i], 1'b0);
      step(c[0], 1'b1);
      chk("R6 clear wins over access", 32'(lbrdy_n), 32'd0);
      chk("R1 byte 7C", 32'(data), 32'h07c);
    end
    host_acc = 1'b1;
    @(negedge clk);
    host_acc = 1'b0; m_lbrdy_n = 1'b1;
    chk("R6 later access sets", 32'(lbrdy_n), 32'd1);

    // R8 every code decodes
    for (int n = 0; n < 16; n++) begin
      logic [9:0] c;
      c = {CODE[n], CODE[15-n]};
      for (int i = 9; i >= 0; i--) step(c[i], 1'b0);
      chk("R8 decode", 32'(data), 32'({2'b00, 4'(n), 4'(15-n)}));
    end

    // R10 strobe gating
    begin
      logic [9:0] d0;
      logic s0, b0, y0;
      d0 = data; s0 = sync_n; b0 = brdy_n; y0 = syn_n;
      for (int k = 0; k < 6; k++) begin
        bit_in = k[0];
        @(negedge clk);
      end
      chk("R10 data held", 32'(data), 32'(d0));
      chk("R10 flags held", 32'({s0, b0, y0}), 32'({sync_n, brdy_n, syn_n}));
    end

    // R9 idle clears shift and flags
    for (int k = 0; k < 10; k++) step(1'b1, 1'b0);
    chk("R2 sync before idle", 32'(sync_n), 32'd0);
    run = 1'b0;
    @(negedge clk);
    run = 1'b1;
    chk("R9 flags idle", 32'({sync_n, brdy_n, lbrdy_n, syn_n, err_n}), 32'h1f);
    model_clear();
    step(1'b1, 1'b0);
    chk("R9 shift cleared", 32'(sync_n), 32'd1);

    // R7 write mode
    rd_mode = 1'b0;
    wr_data = 8'h3a;
    @(negedge clk);
    chk("R7 write pattern", 32'(data), 32'({CODE[4'h3], CODE[4'ha]}));
    wr_sync = 1'b1;
    @(negedge clk);
    chk("R7 write sync", 32'(data), 32'h3ff);
    wr_sync = 1'b0;
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0);
    rd_mode = 1'b1;

    // R11 async reset mid-stream
    for (int k = 0; k < 10; k++) step(1'b1, 1'b0);
    #2 rst_n = 1'b0;
    #1 chk("R11 async reset", 32'({sync_n, brdy_n, lbrdy_n, syn_n}), 32'hf);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

endmodule